// File: doc/BRIEF.md
# Single-Precision to Signed Integer Converter

This unit takes a 32-bit IEEE 754 single-precision operand and returns a 32-bit signed two's-complement integer. Rounding follows a 2-bit mode field supplied with each operation, normally taken from the processor status word. The datapath has three register stages. A new operation may be issued on every cycle. The result and the matching exception-flag update leave the unit together, three cycles after issue.

The inexact, invalid and flush-to-zero conditions are reported on a per-operation flag-update vector. A sticky flag register is built in. It collects that vector together with the update vectors of other arithmetic units that retire in the same cycle, and it clears only on an explicit status-word write. Each operation carries a guard bit. When the guard bit is 0, the operation writes no result and makes no flag update.

Top module: `fp2int_conv`

## Requirements
- R1: An operation sampled with `issue_i`=1 and `guard_i`=1 makes `res_valid_o`=1 after exactly three rising clock edges. In that same cycle `res_o` and `flag_upd_o` carry its result and its flags. When `res_valid_o`=0, `flag_upd_o` is 0.
- R2: `rmode_i` selects the rounding mode: 00 nearest with ties to even, 01 toward zero, 10 toward +infinity, 11 toward -infinity. The result is the rounded value of the operand.
- R3: The flag vector bits are: bit 0 inexact, bit 1 invalid, bit 2 flushed. An in-range finite result that differs from the operand sets bit 0 only. An exact result sets no bit.
- R4: An operand with exponent 0 and a nonzero fraction (a denormal) gives result 0 with only bit 2 set. An operand of +0 or -0 gives 0 with no flags.
- R5: A positive operand whose rounded value exceeds 2^31-1, including +infinity, gives 0x7FFFFFFF. A negative operand whose rounded value is below -2^31, including -infinity, gives 0x80000000. In both cases only bit 1 is set.
- R6: A negative operand that rounds to exactly -2^31 is in range. It gives 0x80000000 with no invalid flag.
- R7: Any NaN operand, quiet or signalling, gives 0 with only bit 1 set.
- R8: An operation sampled with `guard_i`=0 produces no `res_valid_o` pulse and no flag update. It leaves `sticky_o` unchanged.
- R9: At each clock edge, each bit of `sticky_o` becomes its previous value ORed with the same bit of `flag_upd_o` and of every external update in `ext_upd_i`. Set bits stay set until an explicit write.
- R10: When `sw_wr_i`=1, the register takes `sw_wdata_i`, with the same cycle's updates ORed on top. An explicit write and an update in one cycle therefore keep both.
- R11: During reset `res_valid_o`, `flag_upd_o` and `sticky_o` are all 0.
- R12: Operations issued on consecutive cycles each produce their own result in issue order, one per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue_i | input | 1 | Operation issued this cycle |
| guard_i | input | 1 | Guard bit (LSB of guard); tie to 1 for unguarded use |
| rmode_i | input | 2 | Rounding mode |
| operand_i | input | 32 | Single-precision operand |
| res_valid_o | output | 1 | Result write strobe |
| res_o | output | 32 | Signed integer result |
| flag_upd_o | output | 3 | Flag update from this unit {flushed, invalid, inexact} |
| ext_upd_i | input | 3*NUM_EXT_SRC | Flag updates from other units, 3 bits per source |
| sw_wr_i | input | 1 | Explicit status-word flag write |
| sw_wdata_i | input | 3 | Value for the explicit write |
| sticky_o | output | 3 | Sticky exception flags |

## Verification
A wrong operand class or shift amount held in the first or second stage appears on `res_o` or `flag_upd_o` exactly three cycles after the operation is issued. It affects only that one result, because each stage holds only one operation. A lost or extra valid bit in the pipeline shows as a missing or extra result strobe in that same cycle, or as results that shift out of issue order. A corrupted sticky bit appears on `sticky_o` on the next cycle. It persists until the next explicit write, so any later sample shows it.

// File: rtl/f2i_pkg.sv
`timescale 1ns/1ps
package f2i_pkg;
  localparam int EXP_W   = 8;
  localparam int MAN_W   = 23;
  localparam int INT_W   = 32;
  localparam int FLAG_W  = 3;
  localparam int BIAS    = 127;
  localparam int FRAC_W  = INT_W;            // fraction bits kept in the alignment window
  localparam int WIN_W   = INT_W + FRAC_W;
  localparam int SHIFT_W = $clog2(WIN_W);

  // flag bit positions
  localparam int FLG_INEXACT = 0;
  localparam int FLG_INVALID = 1;
  localparam int FLG_FLUSH   = 2;

  // exponent where the window shift is zero, and the largest exponent still converted
  localparam logic [EXP_W-1:0] EXP_TINY = EXP_W'(BIAS - FRAC_W + MAN_W);
  localparam logic [EXP_W-1:0] EXP_TOP  = EXP_W'(BIAS + INT_W - 1);
  localparam logic [EXP_W-1:0] EXP_MAX  = {EXP_W{1'b1}};

  typedef enum logic [1:0] {
    RM_NEAREST_EVEN = 2'b00,
    RM_TO_ZERO      = 2'b01,
    RM_TO_POS       = 2'b10,
    RM_TO_NEG       = 2'b11
  } rmode_e;

  typedef enum logic [2:0] {
    CL_ZERO, CL_FLUSH, CL_NAN, CL_HUGE, CL_NORM
  } cls_e;

  typedef struct packed {
    logic                sign;
    cls_e                cls;
    logic                tiny;
    logic [SHIFT_W-1:0]  shamt;
    logic [MAN_W:0]      mant;
    rmode_e              rmode;
  } s1_t;

  typedef struct packed {
    logic                sign;
    cls_e                cls;
    logic [INT_W-1:0]    mag;
    logic                rnd;
    logic                stk;
    rmode_e              rmode;
  } s2_t;
endpackage

// File: rtl/f2i_decode.sv
`timescale 1ns/1ps
module f2i_decode
  import f2i_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [1:0]       rmode,
  input  logic [INT_W-1:0] operand,
  output logic             out_valid,
  output s1_t              s1_q
);
  s1_t              s1_d;
  logic [EXP_W-1:0] expo;
  logic [MAN_W-1:0] frac;

  always_comb begin
    expo        = operand[INT_W-2 -: EXP_W];
    frac        = operand[MAN_W-1:0];
    s1_d        = '0;
    s1_d.sign   = operand[INT_W-1];
    s1_d.mant   = {(expo != '0), frac};
    s1_d.rmode  = rmode_e'(rmode);
    s1_d.tiny   = (expo < EXP_TINY);
    s1_d.shamt  = SHIFT_W'(expo - EXP_TINY);
    if (expo == '0)
      s1_d.cls = (frac == '0) ? CL_ZERO : CL_FLUSH;
    else if (expo == EXP_MAX)
      s1_d.cls = (frac != '0) ? CL_NAN : CL_HUGE;
    else if (expo > EXP_TOP)
      s1_d.cls = CL_HUGE;
    else
      s1_d.cls = CL_NORM;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_valid <= 1'b0;
    else        out_valid <= in_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        s1_q <= '0;
    else if (in_valid) s1_q <= s1_d;
  end
endmodule

// File: rtl/f2i_align.sv
`timescale 1ns/1ps
module f2i_align
  import f2i_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  input  s1_t  s1,
  output logic out_valid,
  output s2_t  s2_q
);
  s2_t              s2_d;
  logic [WIN_W-1:0] win;

  always_comb begin
    win         = {{(WIN_W-MAN_W-1){1'b0}}, s1.mant} << s1.shamt;
    s2_d        = '0;
    s2_d.sign   = s1.sign;
    s2_d.cls    = s1.cls;
    s2_d.rmode  = s1.rmode;
    if (s1.cls == CL_NORM) begin
      if (s1.tiny) begin
        s2_d.stk = 1'b1;                      // nonzero, below the window
      end else begin
        s2_d.mag = win[WIN_W-1 -: INT_W];
        s2_d.rnd = win[FRAC_W-1];
        s2_d.stk = |win[FRAC_W-2:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_valid <= 1'b0;
    else        out_valid <= in_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        s2_q <= '0;
    else if (in_valid) s2_q <= s2_d;
  end
endmodule

// File: rtl/f2i_round.sv
`timescale 1ns/1ps
module f2i_round
  import f2i_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  s2_t               s2,
  output logic              out_valid,
  output logic [INT_W-1:0]  res,
  output logic [FLAG_W-1:0] flags
);
  localparam logic [INT_W:0] POS_LIM = {2'b00, {(INT_W-1){1'b1}}};
  localparam logic [INT_W:0] NEG_LIM = {2'b01, {(INT_W-1){1'b0}}};

  logic              up, inexact, ovf;
  logic [INT_W:0]    mag_r;
  logic [INT_W-1:0]  sat, res_d, res_q;
  logic [FLAG_W-1:0] flg_d, flg_q;

  always_comb begin
    inexact = s2.rnd | s2.stk;
    unique case (s2.rmode)
      RM_NEAREST_EVEN: up = s2.rnd & (s2.stk | s2.mag[0]);
      RM_TO_ZERO:      up = 1'b0;
      RM_TO_POS:       up = ~s2.sign & inexact;
      RM_TO_NEG:       up = s2.sign & inexact;
      default:         up = 1'b0;
    endcase
    mag_r = {1'b0, s2.mag} + {{INT_W{1'b0}}, up};
    ovf   = s2.sign ? (mag_r > NEG_LIM) : (mag_r > POS_LIM);
    sat   = s2.sign ? {1'b1, {(INT_W-1){1'b0}}} : {1'b0, {(INT_W-1){1'b1}}};
    res_d = '0;
    flg_d = '0;
    case (s2.cls)
      CL_ZERO:  ;
      CL_FLUSH: flg_d[FLG_FLUSH] = 1'b1;
      CL_NAN:   flg_d[FLG_INVALID] = 1'b1;
      CL_HUGE: begin
        res_d              = sat;
        flg_d[FLG_INVALID] = 1'b1;
      end
      default: begin
        if (ovf) begin
          res_d              = sat;
          flg_d[FLG_INVALID] = 1'b1;
        end else begin
          res_d              = s2.sign ? ({INT_W{1'b0}} - mag_r[INT_W-1:0])
                                       : mag_r[INT_W-1:0];
          flg_d[FLG_INEXACT] = inexact;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_valid <= 1'b0;
    else        out_valid <= in_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0;
      flg_q <= '0;
    end else if (in_valid) begin
      res_q <= res_d;
      flg_q <= flg_d;
    end
  end

  assign res   = res_q;
  assign flags = out_valid ? flg_q : '0;
endmodule

// File: rtl/f2i_sticky_flags.sv
`timescale 1ns/1ps
module f2i_sticky_flags
  import f2i_pkg::*;
#(
  parameter int NUM_SRC = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_i,
  input  logic [FLAG_W-1:0]         wdata_i,
  input  logic [NUM_SRC*FLAG_W-1:0] upd_i,
  output logic [FLAG_W-1:0]         flags_o
);
  logic [FLAG_W-1:0] base, merged, flags_q;
  logic              load;

  assign base = wr_i ? wdata_i : flags_q;
  assign load = wr_i | (|upd_i);

  for (genvar b = 0; b < FLAG_W; b++) begin : g_bit
    logic [NUM_SRC-1:0] col;
    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
      assign col[s] = upd_i[s*FLAG_W + b];
    end
    assign merged[b] = base[b] | (|col);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    flags_q <= '0;
    else if (load) flags_q <= merged;
  end

  assign flags_o = flags_q;
endmodule

// File: rtl/fp2int_conv.sv
`timescale 1ns/1ps
module fp2int_conv
  import f2i_pkg::*;
#(
  parameter int NUM_EXT_SRC = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          issue_i,
  input  logic                          guard_i,
  input  logic [1:0]                    rmode_i,
  input  logic [INT_W-1:0]              operand_i,
  output logic                          res_valid_o,
  output logic [INT_W-1:0]              res_o,
  output logic [FLAG_W-1:0]             flag_upd_o,
  input  logic [NUM_EXT_SRC*FLAG_W-1:0] ext_upd_i,
  input  logic                          sw_wr_i,
  input  logic [FLAG_W-1:0]             sw_wdata_i,
  output logic [FLAG_W-1:0]             sticky_o
);
  localparam int NUM_SRC = NUM_EXT_SRC + 1;

  logic op_go, v1, v2;
  s1_t  s1;
  s2_t  s2;

  assign op_go = issue_i & guard_i;

  f2i_decode u_decode (
    .clk(clk), .rst_n(rst_n), .in_valid(op_go), .rmode(rmode_i),
    .operand(operand_i), .out_valid(v1), .s1_q(s1)
  );

  f2i_align u_align (
    .clk(clk), .rst_n(rst_n), .in_valid(v1), .s1(s1),
    .out_valid(v2), .s2_q(s2)
  );

  f2i_round u_round (
    .clk(clk), .rst_n(rst_n), .in_valid(v2), .s2(s2),
    .out_valid(res_valid_o), .res(res_o), .flags(flag_upd_o)
  );

  f2i_sticky_flags #(.NUM_SRC(NUM_SRC)) u_sticky (
    .clk(clk), .rst_n(rst_n), .wr_i(sw_wr_i), .wdata_i(sw_wdata_i),
    .upd_i({ext_upd_i, flag_upd_o}), .flags_o(sticky_o)
  );
endmodule

// File: rtl/fp2int_conv_chk.sv
`timescale 1ns/1ps
module fp2int_conv_chk
  import f2i_pkg::*;
#(
  parameter int NUM_EXT_SRC = 2
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          issue_i,
  input logic                          guard_i,
  input logic                          res_valid_o,
  input logic [INT_W-1:0]              res_o,
  input logic [FLAG_W-1:0]             flag_upd_o,
  input logic                          sw_wr_i,
  input logic [FLAG_W-1:0]             sw_wdata_i,
  input logic [FLAG_W-1:0]             sticky_o
);
  logic [1:0] cyc;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cyc <= '0;
    else if (cyc != 2'd3) cyc <= cyc + 2'd1;
  end

  assert_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc == 2'd3) |-> (res_valid_o == $past(issue_i && guard_i, 3)));

  assert_quiet_flags_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid_o |-> (flag_upd_o == '0));

  assert_flush_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid_o && flag_upd_o[FLG_FLUSH]) |->
      (res_o == '0 && $countones(flag_upd_o) == 1));

  assert_invalid_value_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid_o && flag_upd_o[FLG_INVALID]) |->
      (res_o == '0 || res_o == 32'h7FFF_FFFF || res_o == 32'h8000_0000));

  assert_sticky_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !sw_wr_i |=> ((sticky_o & $past(sticky_o)) == $past(sticky_o)));

  assert_sticky_takes_upd_R9: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid_o |=> ((sticky_o & $past(flag_upd_o)) == $past(flag_upd_o)));

  assert_write_kept_R10: assert property (@(posedge clk) disable iff (!rst_n)
    sw_wr_i |=> ((sticky_o & $past(sw_wdata_i)) == $past(sw_wdata_i)));
endmodule

bind fp2int_conv fp2int_conv_chk #(.NUM_EXT_SRC(NUM_EXT_SRC)) u_chk (
  .clk(clk), .rst_n(rst_n), .issue_i(issue_i), .guard_i(guard_i),
  .res_valid_o(res_valid_o), .res_o(res_o), .flag_upd_o(flag_upd_o),
  .sw_wr_i(sw_wr_i), .sw_wdata_i(sw_wdata_i), .sticky_o(sticky_o)
);

// File: tb/fp2int_conv_tb.sv
`timescale 1ns/1ps
module fp2int_conv_tb;
  localparam int NEXT = 2;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        issue_i, guard_i, sw_wr_i;
  logic [1:0]  rmode_i;
  logic [31:0] operand_i, res_o;
  logic        res_valid_o;
  logic [2:0]  flag_upd_o, sw_wdata_i, sticky_o;
  logic [3*NEXT-1:0] ext_upd_i;

  fp2int_conv #(.NUM_EXT_SRC(NEXT)) u_dut (
    .clk(clk), .rst_n(rst_n), .issue_i(issue_i), .guard_i(guard_i),
    .rmode_i(rmode_i), .operand_i(operand_i), .res_valid_o(res_valid_o),
    .res_o(res_o), .flag_upd_o(flag_upd_o), .ext_upd_i(ext_upd_i),
    .sw_wr_i(sw_wr_i), .sw_wdata_i(sw_wdata_i), .sticky_o(sticky_o)
  );

  always #4 clk = ~clk;

  int n_chk = 0, n_bad = 0, n_issued = 0, n_seen = 0, drv_cyc = 0;
  bit done = 1'b0, pred_ok = 1'b0;
  logic [2:0] pred;

  typedef struct { logic v; logic [31:0] r; logic [2:0] f; logic [31:0] op; } exp_t;
  exp_t q[$];

  function automatic void model(input logic [31:0] op, input logic [1:0] rm,
                                output logic [31:0] r, output logic [2:0] fl);
    logic [7:0] e; logic s;
    longint unsigned m, qv, rem, half, mag;
    int ue, sh, cmp; bit ex, inc;
    e = op[30:23]; s = op[31]; r = '0; fl = '0;
    if (e == 8'd0) begin if (op[22:0] != 0) fl = 3'b100; return; end
    if (e == 8'hFF) begin
      fl = 3'b010;
      if (op[22:0] == 0) r = s ? 32'h8000_0000 : 32'h7FFF_FFFF;
      return;
    end
    ue = int'(e) - 127;
    m  = {40'd0, 1'b1, op[22:0]};
    if (ue > 40) begin r = s ? 32'h8000_0000 : 32'h7FFF_FFFF; fl = 3'b010; return; end
    if (ue >= 23) begin qv = m << (ue - 23); ex = 1'b1; cmp = -1; end
    else begin
      sh = 23 - ue;
      if (sh >= 40) begin qv = 0; ex = 1'b0; cmp = -1; end
      else begin
        qv = m >> sh; rem = m - (qv << sh); half = 64'd1 << (sh - 1);
        ex = (rem == 0); cmp = (rem < half) ? -1 : (rem == half) ? 0 : 1;
      end
    end
    case (rm)
      2'b00: inc = (cmp > 0) || (cmp == 0 && qv[0]);
      2'b01: inc = 1'b0;
      2'b10: inc = !s && !ex;
      default: inc = s && !ex;
    endcase
    mag = qv + longint'(inc);
    if ((!s && mag > 64'd2147483647) || (s && mag > 64'd2147483648)) begin
      r = s ? 32'h8000_0000 : 32'h7FFF_FFFF; fl = 3'b010;
    end else begin
      r = s ? 32'(64'd0 - mag) : mag[31:0];
      fl = {2'b00, !ex};
    end
  endfunction

  function automatic string tag_of(input exp_t x);
    if (x.op[30:23] == 8'd0) return "R4";
    if (x.op[30:23] == 8'hFF && x.op[22:0] != 0) return "R7";
    if (x.f[1]) return "R5";
    if (x.op == 32'hCF00_0000) return "R6";
    if (x.f[0]) return "R3";
    return "R2";
  endfunction

  // scoreboard: check at negedge, record what the next edge samples
  always @(negedge clk) begin
    exp_t x;
    logic [2:0] ext_or;
    if (rst_n && !done) begin
      if (q.size() == 3) begin
        x = q.pop_front();
        n_chk++;
        if (res_valid_o !== x.v) begin
          n_bad++;
          $display("FAIL %s valid op=%h got=%b exp=%b", x.v ? "R1" : "R8", x.op, res_valid_o, x.v);
        end else if (x.v && (res_o !== x.r || flag_upd_o !== x.f)) begin
          n_bad++;
          $display("FAIL %s op=%h got=%h/%b exp=%h/%b", tag_of(x), x.op, res_o, flag_upd_o, x.r, x.f);
        end else if (!x.v && flag_upd_o !== 3'b000) begin
          n_bad++;
          $display("FAIL R8 flag update without result got=%b exp=000", flag_upd_o);
        end
        if (res_valid_o) n_seen++;
      end
      if (pred_ok) begin
        n_chk++;
        if (sticky_o !== pred) begin
          n_bad++;
          $display("FAIL R9/R10 sticky got=%b exp=%b", sticky_o, pred);
        end
      end
    end
    #2;
    if (rst_n && !done) begin
      x.v = issue_i && guard_i; x.op = operand_i;
      model(operand_i, rmode_i, x.r, x.f);
      q.push_back(x);
      ext_or = '0;
      for (int k = 0; k < NEXT; k++) ext_or = ext_or | ext_upd_i[3*k +: 3];
      pred = (sw_wr_i ? sw_wdata_i : pred) | flag_upd_o | ext_or;
      pred_ok = 1'b1;
    end
  end

  task automatic drive(input logic iss, input logic [31:0] op, input logic [1:0] rm, input logic g);
    @(negedge clk); #1;
    drv_cyc++;
    issue_i = iss; operand_i = op; rmode_i = rm; guard_i = g;
    ext_upd_i = (drv_cyc % 37 == 0) ? 6'(drv_cyc % 64) : '0;
    sw_wr_i   = (drv_cyc % 53 == 0);
    sw_wdata_i = 3'(drv_cyc / 53);
    if (iss && g) n_issued++;
  endtask

  function automatic logic [22:0] mpick(input int i);
    case (i)
      0: return 23'h000000;  1: return 23'h000001;  2: return 23'h400000;
      3: return 23'h7FFFFF;  4: return 23'h400001;  default: return 23'h3FFFFF;
    endcase
  endfunction

  initial begin
    logic [31:0] dir [12];
    int n;
    dir = '{32'h40400000, 32'h40247AE1, 32'hFF4FFFFF, 32'h7F800000, 32'hBFC147AE,
            32'h00400000, 32'hFFFFFFFF, 32'hFFBFFFFF, 32'h3F000000, 32'h3FC00000,
            32'h40200000, 32'hC0200000};
    rst_n = 1'b0; issue_i = 0; guard_i = 0; rmode_i = 0; operand_i = 0;
    ext_upd_i = 0; sw_wr_i = 0; sw_wdata_i = 0; pred = 3'b000;
    repeat (4) @(negedge clk);
    n_chk++;   // R11 reset state
    if (res_valid_o !== 1'b0 || flag_upd_o !== 3'b000 || sticky_o !== 3'b000) begin
      n_bad++;
      $display("FAIL R11 reset got=%b/%b/%b exp=0/000/000", res_valid_o, flag_upd_o, sticky_o);
    end
    #1 rst_n = 1'b1;
    // directed values in every rounding mode (R2, R3, R5, R7)
    for (int i = 0; i < 12; i++)
      for (int rm = 0; rm < 4; rm++) drive(1'b1, dir[i], 2'(rm), 1'b1);
    // near-exhaustive exponent sweep, back to back (R12), with guarded-off slots (R8)
    n = 0;
    for (int sg = 0; sg < 2; sg++)
      for (int ex = 0; ex < 256; ex++)
        for (int mi = 0; mi < 6; mi++)
          for (int rm = 0; rm < 4; rm++) begin
            n++;
            drive(1'b1, {1'(sg), 8'(ex), mpick(mi)}, 2'(rm), (n % 7) != 3);
            if (n % 13 == 0) drive(1'b0, 32'h0, 2'd0, 1'b1);
          end
    repeat (6) drive(1'b0, 32'h0, 2'd0, 1'b0);
    // R10: explicit clear and external update in the same cycle
    @(negedge clk); #1;
    sw_wr_i = 1'b1; sw_wdata_i = 3'b000; ext_upd_i = 6'b000_001;
    @(negedge clk); #1;
    sw_wr_i = 1'b0; ext_upd_i = '0;
    @(negedge clk);
    n_chk++;
    if (sticky_o !== 3'b001) begin
      n_bad++;
      $display("FAIL R10 write+update got=%b exp=001", sticky_o);
    end
    repeat (4) @(negedge clk);
    n_chk++;
    if (n_seen != n_issued) begin
      n_bad++;
      $display("FAIL R12 result count got=%0d exp=%0d", n_seen, n_issued);
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog expired got=running exp=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule